// File: doc/BRIEF.md
# Dual-Channel PDM Microphone Receiver

This block drives the shift clock for one or two pulse-density-modulated microphones and gathers their one-bit samples from a single shared data input. The two microphones take turns on that line within each clock period. The left microphone's bit is taken when the microphone clock goes high, and the right microphone's bit when it goes low. Each captured bit appears on its own output together with a one-cycle valid strobe. Decimation and the pad circuitry are handled outside the block.

The microphone clock is the system clock divided by an even ratio, twice a programmable half-period. The block runs only when the power controls of at least one channel say so. When it is off, the microphone clock is parked low. The outputs are free-running sample streams with no ready input. The microphones cannot be paused, so no back-pressure is accepted, and a consumer must take each bit in the cycle its strobe is high.

Top module: `pdm_mic_rx`

## Requirements
- R1: The block is enabled when (`adc_on_a`=1 and `mic_pdn_a`=0) or (`adc_on_b`=1 and `mic_pdn_b`=0). It is disabled for every other combination of these four inputs.
- R2: While enabled, `mic_clk` spends exactly H system cycles high and H cycles low in each period, where H is the effective half-period.
- R3: At each rising edge of `mic_clk`, `left_bit` takes the value `mic_sd` had in the last system cycle before that edge. `left_valid` is 1 for exactly the first system cycle in which `mic_clk` is high.
- R4: At each falling edge of `mic_clk` while enabled, `right_bit` takes the value `mic_sd` had in the last system cycle before that edge. `right_valid` is 1 for exactly the first system cycle in which `mic_clk` is low.
- R5: `left_valid` and `right_valid` are never 1 in the same cycle, and neither is 1 in the cycle after a cycle in which the block was disabled.
- R6: While the block is disabled and `mic_clk` is low, `mic_clk` stays low. After an enable from the parked state, the first edge is rising and it occurs after H system clock edges.
- R7: A disable that arrives while `mic_clk` is high lets the high phase run its full H cycles. The clock then falls and stays low, and that final fall raises no `right_valid`.
- R8: While `rst_n` is low, `mic_clk`, `left_bit`, `right_bit`, `left_valid` and `right_valid` are all 0.
- R9: H equals `half_period`, but a `half_period` below 2 is treated as 2, which gives a minimum ratio of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| half_period | input | DIV_W | Microphone clock half-period in system cycles |
| adc_on_a | input | 1 | Channel A converter power control (1 = on) |
| mic_pdn_a | input | 1 | Channel A microphone power-down (1 = down) |
| adc_on_b | input | 1 | Channel B converter power control (1 = on) |
| mic_pdn_b | input | 1 | Channel B microphone power-down (1 = down) |
| mic_sd | input | 1 | Shared PDM data line from both microphones |
| mic_clk | output | 1 | Shift clock to the microphones |
| left_bit | output | 1 | Latest left-channel bit |
| left_valid | output | 1 | One-cycle strobe for a new left bit |
| right_bit | output | 1 | Latest right-channel bit |
| right_valid | output | 1 | One-cycle strobe for a new right bit |

## Verification
Two functions can meet in a single cycle: the end of a high phase, which produces a falling edge and a right capture, and a disable from the power controls. The bench provokes this by dropping the enable one cycle after a rising edge. It then checks that the high phase still lasts the full H cycles, that the clock parks low afterwards, and that the forced fall adds no right strobe. The two capture strobes are separate functions that could in principle also coincide. A live model of the microphones drives fresh data every cycle and checks that each strobe matches the value on the line just before its own edge, and that the two strobes never arrive together.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int N_CH = 2;
  localparam int MIN_HALF = 2;

  typedef struct packed {
    logic adc_on;
    logic mic_pdn;
  } ch_pwr_t;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } cap_edge_e;
endpackage

// File: rtl/pdm_pwr_decode.sv
module pdm_pwr_decode
  import pdm_pkg::*;
(
  input  ch_pwr_t [N_CH-1:0] pwr,
  output logic               enable
);
  logic [N_CH-1:0] ch_on;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign ch_on[g] = pwr[g].adc_on & ~pwr[g].mic_pdn;
  end

  assign enable = |ch_on;
endmodule

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
  import pdm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] half_period,
  output logic             mic_clk,
  output logic             rise_now,
  output logic             fall_now
);
  localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             run;
  logic             wrap;

  assign lim      = (half_period < MIN_H) ? MIN_H : half_period;
  assign run      = enable | mic_clk;
  assign wrap     = run && (cnt >= lim - DIV_W'(1));
  assign rise_now = wrap && !mic_clk && enable;
  assign fall_now = wrap && mic_clk && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      mic_clk <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt     <= '0;
      mic_clk <= ~mic_clk;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R6: parked clock stays low while disabled
  a_r6_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !mic_clk) |=> !mic_clk);
  // R2/R7: a high phase never ends one cycle after it starts
  a_r7_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mic_clk) |=> mic_clk);
endmodule

// File: rtl/pdm_capture.sv
module pdm_capture
  import pdm_pkg::*;
#(
  parameter cap_edge_e EDGE = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sd,
  output logic bit_q,
  output logic valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take;
      if (take) bit_q <= sd;
    end
  end

  // R3/R4: each strobe lasts a single cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/pdm_mic_rx.sv
module pdm_mic_rx
  import pdm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_period,
  input  logic             adc_on_a,
  input  logic             mic_pdn_a,
  input  logic             adc_on_b,
  input  logic             mic_pdn_b,
  input  logic             mic_sd,
  output logic             mic_clk,
  output logic             left_bit,
  output logic             left_valid,
  output logic             right_bit,
  output logic             right_valid
);
  ch_pwr_t [N_CH-1:0] pwr;
  logic               enable;
  logic               rise_now;
  logic               fall_now;
  logic [N_CH-1:0]    take;
  logic [N_CH-1:0]    bits;
  logic [N_CH-1:0]    vals;

  assign pwr[0] = '{adc_on: adc_on_a, mic_pdn: mic_pdn_a};
  assign pwr[1] = '{adc_on: adc_on_b, mic_pdn: mic_pdn_b};

  pdm_pwr_decode u_dec (
    .pwr    (pwr),
    .enable (enable)
  );

  pdm_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .half_period (half_period),
    .mic_clk     (mic_clk),
    .rise_now    (rise_now),
    .fall_now    (fall_now)
  );

  assign take[0] = rise_now;
  assign take[1] = fall_now;

  for (genvar g = 0; g < N_CH; g++) begin : g_cap
    pdm_capture #(.EDGE(g == 0 ? EDGE_RISE : EDGE_FALL)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take[g]),
      .sd      (mic_sd),
      .bit_q   (bits[g]),
      .valid_q (vals[g])
    );
  end

  assign left_bit    = bits[0];
  assign left_valid  = vals[0];
  assign right_bit   = bits[1];
  assign right_valid = vals[1];

  a_r3_left_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |-> (mic_clk && !$past(mic_clk)));
  a_r4_right_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |-> (!mic_clk && $past(mic_clk)));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid));
  a_r5_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!left_valid && !right_valid));
endmodule

// File: tb/sim_pdm_mic_rx.sv
module sim_pdm_mic_rx;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [DIV_W-1:0] half_period;
  logic             adc_on_a, mic_pdn_a, adc_on_b, mic_pdn_b;
  logic             mic_sd;
  logic             mic_clk, left_bit, left_valid, right_bit, right_valid;

  pdm_mic_rx #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .adc_on_a(adc_on_a), .mic_pdn_a(mic_pdn_a),
    .adc_on_b(adc_on_b), .mic_pdn_b(mic_pdn_b),
    .mic_sd(mic_sd), .mic_clk(mic_clk),
    .left_bit(left_bit), .left_valid(left_valid),
    .right_bit(right_bit), .right_valid(right_valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {adc_on_a, mic_pdn_a, adc_on_b, mic_pdn_b, expected enable} (R1)
  localparam logic [4:0] VEC [16] = '{
    5'b0000_0, 5'b0001_0, 5'b0010_1, 5'b0011_0,
    5'b0100_0, 5'b0101_0, 5'b0110_1, 5'b0111_0,
    5'b1000_1, 5'b1001_1, 5'b1010_1, 5'b1011_1,
    5'b1100_0, 5'b1101_0, 5'b1110_1, 5'b1111_0
  };

  // Microphone model and data checker
  logic [15:0] lfsr = 16'hACE1;
  logic low_val = 1'b0, high_val = 1'b0, prev_clk = 1'b0;
  bit   chk_data = 1'b0;
  int   lv_cnt = 0, rv_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (left_valid) lv_cnt++;
      if (right_valid) rv_cnt++;
      if (chk_data) begin
        if (left_valid)
          check(left_bit == low_val && mic_clk && !prev_clk, "R3 left bit", int'(left_bit), int'(low_val));
        if (right_valid)
          check(right_bit == high_val && !mic_clk && prev_clk, "R4 right bit", int'(right_bit), int'(high_val));
        if (left_valid && right_valid)
          check(1'b0, "R5 both strobes", 1, 0);
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mic_clk) high_val = lfsr[0];
    else         low_val  = lfsr[0];
    mic_sd   = lfsr[0];
    prev_clk = mic_clk;
  end

  task automatic set_pwr(input logic [3:0] p);
    {adc_on_a, mic_pdn_a, adc_on_b, mic_pdn_b} = p;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic park();
    set_pwr(4'b0101);
    cycles(40);
  endtask

  task automatic measure(input int hp, input int exp_h, input string tag);
    int hi, lo;
    half_period = DIV_W'(hp);
    set_pwr(4'b1000);
    while (mic_clk) @(negedge clk);
    while (!mic_clk) @(negedge clk);
    while (mic_clk) @(negedge clk);
    while (!mic_clk) @(negedge clk);
    hi = 0;
    while (mic_clk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!mic_clk) begin lo++; @(negedge clk); end
    check(hi == exp_h, {tag, " high length"}, hi, exp_h);
    check(lo == exp_h, {tag, " low length"}, lo, exp_h);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int tog, lv0, rv0, k, hi;
    logic pc;
    rst_n = 1'b0;
    half_period = DIV_W'(2);
    set_pwr(4'b1000);
    mic_sd = 1'b0;
    cycles(6);
    // R8: reset state even with enable requested
    check({mic_clk, left_bit, left_valid, right_bit, right_valid} == 5'b0,
          "R8 reset outputs", int'({mic_clk, left_bit, left_valid, right_bit, right_valid}), 0);
    set_pwr(4'b0000);
    rst_n = 1'b1;
    cycles(4);

    // R1 table walk with R5 quiet check
    for (int v = 0; v < 16; v++) begin
      set_pwr(VEC[v][4:1]);
      lv0 = lv_cnt; rv0 = rv_cnt;
      tog = 0; pc = mic_clk;
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        if (mic_clk != pc) tog++;
        pc = mic_clk;
      end
      check((tog > 0) == VEC[v][0], "R1 enable table", tog, int'(VEC[v][0]));
      if (!VEC[v][0])
        check(lv_cnt == lv0 && rv_cnt == rv0, "R5 no strobe while off", lv_cnt + rv_cnt - lv0 - rv0, 0);
      park();
      check(mic_clk == 1'b0, "R6 parked low", int'(mic_clk), 0);
    end

    // R3/R4/R5 data capture with live microphone model
    half_period = DIV_W'(3);
    lv0 = lv_cnt; rv0 = rv_cnt;
    chk_data = 1'b1;
    set_pwr(4'b0010);
    cycles(300);
    chk_data = 1'b0;
    check(lv_cnt - lv0 >= 45, "R3 left strobe count", lv_cnt - lv0, 49);
    check(rv_cnt - rv0 >= 45, "R4 right strobe count", rv_cnt - rv0, 49);
    park();

    // R2/R9 period per half setting
    measure(2, 2, "R2 h=2");
    measure(3, 3, "R2 h=3");
    measure(5, 5, "R2 h=5");
    measure(7, 7, "R2 h=7");
    measure(1, 2, "R9 h=1");
    measure(0, 2, "R9 h=0");
    park();

    // R6: start from parked state, first edge is rising after H edges
    half_period = DIV_W'(4);
    set_pwr(4'b0010);
    k = 0;
    do begin @(negedge clk); k++; end while (!mic_clk && k < 50);
    check(k == 4, "R6 first rise delay", k, 4);

    // R7: disable one cycle into a high phase
    half_period = DIV_W'(5);
    while (mic_clk) @(negedge clk);
    while (!mic_clk) @(negedge clk);
    @(negedge clk);
    set_pwr(4'b0000);
    rv0 = rv_cnt;
    hi = 2;
    while (mic_clk) begin hi++; @(negedge clk); end
    hi = hi - 1;
    check(hi == 5, "R7 full high phase", hi, 5);
    tog = 0;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (mic_clk) tog++; end
    check(tog == 0, "R7 stays low", tog, 0);
    check(rv_cnt == rv0, "R7 no strobe on forced fall", rv_cnt - rv0, 0);

    // R8: reset mid-run
    set_pwr(4'b1000);
    half_period = DIV_W'(2);
    cycles(13);
    rst_n = 1'b0;
    @(negedge clk);
    check({mic_clk, left_bit, left_valid, right_bit, right_valid} == 5'b0,
          "R8 mid-run reset", int'({mic_clk, left_bit, left_valid, right_bit, right_valid}), 0);
    rst_n = 1'b1;
    cycles(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule